// File: doc/BRIEF.md
# DRAM Refresh Debt Scheduler

This block tells a DRAM controller's command arbiter when an auto-refresh is owed. A free-running timer marks one refresh interval every `INTERVAL_CYC` clock cycles. Each mark adds one unit to a refresh debt. Each refresh the arbiter accepts removes one unit. While any debt is outstanding, a normal request is raised. The arbiter may let the debt grow while it serves other traffic.

The debt is capped at `MAX_DEBT`, which defaults to eight. When the debt reaches that cap, an urgent flag tells the arbiter that it must issue a refresh next. With a cap of eight, two refreshes are never more than nine intervals apart. When a refresh is accepted, a busy flag and a clock-enable hold output stay high for `TRFC_CYC` cycles, which covers the refresh cycle time. The arbiter supplies the row address for a refresh itself, so the handshake carries no address.

Top module: `refresh_sched`

## Requirements
- R1: After reset, rfsh_req, rfsh_urgent, rfsh_busy and rfsh_cke_hold are all 0, and the debt and the interval timer are cleared.
- R2: The interval timer marks one interval at the `INTERVAL_CYC`-th rising edge after reset is released, and then every `INTERVAL_CYC` edges. A mark with no accepted grant raises the debt by one, so rfsh_req is 0 after `INTERVAL_CYC`-1 edges and 1 after `INTERVAL_CYC` edges.
- R3: rfsh_req is 1 exactly when the debt is non-zero.
- R4: rfsh_urgent is 1 exactly when the debt equals `MAX_DEBT`.
- R5: An interval mark with the debt already at `MAX_DEBT` leaves the debt at `MAX_DEBT`, so exactly `MAX_DEBT` accepted grants clear it.
- R6: A grant is accepted when rfsh_grant, rfsh_req and not rfsh_busy are all true at a rising edge. An accepted grant lowers the debt by one, and rfsh_busy is then 1 for exactly `TRFC_CYC` cycles, starting at the next edge.
- R7: A grant while rfsh_busy is 1 is ignored: the debt is unchanged and the busy period is not extended.
- R8: A grant while the debt is zero is ignored: rfsh_busy stays 0.
- R9: An accepted grant and an interval mark at the same edge leave the debt unchanged.
- R10: rfsh_cke_hold is 1 in every cycle in which rfsh_busy is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_grant | input | 1 | Arbiter issues the refresh in this cycle |
| rfsh_req | output | 1 | At least one refresh is owed |
| rfsh_urgent | output | 1 | Debt is at the cap; the refresh must go next |
| rfsh_busy | output | 1 | A refresh cycle time is running |
| rfsh_cke_hold | output | 1 | Keep clock enable high for the refresh in progress |

## Verification
The assertions assume that the grant input is a plain level, sampled on each edge. They make no assumption that the arbiter only grants while a request is raised, or only while the block is idle. The bench deliberately drives grants when there is no debt and during a busy period, to show that the block filters them itself. A random grant phase shifts the arbiter's response time relative to the interval marks, so that the debt saturates, collides with a grant on the same edge, and drains. A behavioural model tracks the expected debt and busy countdown on every edge.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Next debt value from the current value, an interval mark and an accepted grant.
  function automatic int unsigned debt_step(int unsigned cur, logic mark, logic take,
                                            int unsigned cap);
    if (mark && !take) return (cur >= cap) ? cap : cur + 1;
    if (take && !mark) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  // Next value of the busy countdown.
  function automatic int unsigned busy_step(int unsigned cur, logic take, int unsigned len);
    if (take) return len;
    return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  output logic mark
);
  localparam int unsigned IW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [IW-1:0] LAST = IW'(INTERVAL_CYC - 1);

  logic [IW-1:0] cnt_q;

  assign mark = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (mark)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R2
  interval_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> (cnt_q == '0));

  // R2
  interval_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mark |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter
  import refresh_pkg::*;
#(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic take,
  output logic owed,
  output logic at_cap
);
  localparam int unsigned DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] CAP = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= DW'(debt_step(int'(debt_q), mark, take, MAX_DEBT));
  end

  assign owed   = (debt_q != '0);
  assign at_cap = (debt_q == CAP);

  // R5
  debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= CAP);

  // R9
  debt_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && take) |=> $stable(debt_q));

  // R6
  debt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mark) |=> (debt_q == $past(debt_q) - 1'b1));

  // R5
  debt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !take && debt_q == CAP) |=> (debt_q == CAP));
endmodule

// File: rtl/rfsh_busy_timer.sv
module rfsh_busy_timer
  import refresh_pkg::*;
#(
  parameter int unsigned TRFC_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic grant_raw,
  output logic busy
);
  localparam int unsigned BW = $clog2(TRFC_CYC + 1);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= BW'(busy_step(int'(left_q), take, TRFC_CYC));
  end

  assign busy = (left_q != '0);

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy);

  // R7
  busy_no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && grant_raw) |=> (left_q == $past(left_q) - 1'b1));

  // R6
  busy_take_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !busy);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned INTERVAL_CYC = 781,
  parameter int unsigned TRFC_CYC     = 12,
  parameter int unsigned MAX_DEBT     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_grant,
  output logic rfsh_req,
  output logic rfsh_urgent,
  output logic rfsh_busy,
  output logic rfsh_cke_hold
);
  // Named internal events
  logic ev_mark;
  logic ev_take;
  logic owed;
  logic at_cap;
  logic busy;

  assign ev_take = rfsh_grant && owed && !busy;

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .mark(ev_mark)
  );

  rfsh_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst_n(rst_n), .mark(ev_mark), .take(ev_take),
    .owed(owed), .at_cap(at_cap)
  );

  rfsh_busy_timer #(.TRFC_CYC(TRFC_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .take(ev_take), .grant_raw(rfsh_grant), .busy(busy)
  );

  assign rfsh_req      = owed;
  assign rfsh_urgent   = at_cap;
  assign rfsh_busy     = busy;
  assign rfsh_cke_hold = busy;

  // R4
  urgent_implies_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_urgent |-> rfsh_req);

  // R8
  idle_grant_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_grant && !rfsh_req && !rfsh_busy) |=> !rfsh_busy);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rfsh_req && !rfsh_busy));
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int INT  = 64;
  localparam int TRFC = 3;
  localparam int MAXD = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic grant = 0;
  logic req, urg, busy, cke;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Behavioural reference state
  int m_tick = 0;
  int m_debt = 0;
  int m_busy = 0;

  always #5 clk = ~clk;

  refresh_sched #(.INTERVAL_CYC(INT), .TRFC_CYC(TRFC), .MAX_DEBT(MAXD)) u0 (
    .clk(clk), .rst_n(rst_n), .rfsh_grant(grant), .rfsh_req(req),
    .rfsh_urgent(urg), .rfsh_busy(busy), .rfsh_cke_hold(cke)
  );

  task automatic check(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_debt = 0; m_busy = 0;
    end else begin
      bit acc, tk;
      acc = grant && (m_debt > 0) && (m_busy == 0);
      tk  = (m_tick == INT - 1);
      m_tick = tk ? 0 : m_tick + 1;
      if (tk && !acc) m_debt = (m_debt < MAXD) ? m_debt + 1 : MAXD;
      else if (acc && !tk) m_debt = m_debt - 1;
      if (acc) m_busy = TRFC;
      else if (m_busy > 0) m_busy = m_busy - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req == (m_debt != 0), "R3 req", req, int'(m_debt != 0));
      check(urg == (m_debt == MAXD), "R4 urgent", urg, int'(m_debt == MAXD));
      check(busy == (m_busy != 0), "R6 busy", busy, int'(m_busy != 0));
      check(cke == (m_busy != 0), "R10 cke_hold", cke, int'(m_busy != 0));
    end
  end

  task automatic wait_tick(int t);
    @(negedge clk);
    while (m_tick != t) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check(req == 0, "R1 req", req, 0);
    check(urg == 0, "R1 urgent", urg, 0);
    check(busy == 0, "R1 busy", busy, 0);
    check(cke == 0, "R1 cke_hold", cke, 0);
    rst_n = 1;
    // R2: first interval mark
    repeat (INT - 1) @(negedge clk);
    check(req == 0, "R2 before mark", req, 0);
    @(negedge clk);
    check(req == 1, "R2 after mark", req, 1);
    // Saturate: idle well past the cap
    repeat (12 * INT) @(negedge clk);
    check(urg == 1, "R4 urgent at cap", urg, 1);
    // R5: exactly MAXD grants clear a saturated debt
    wait_tick(0);
    grant = 1;
    @(negedge clk);
    check(urg == 0, "R4 urgent after one grant", urg, 0);
    repeat (4 * MAXD - 1) @(negedge clk);
    grant = 0;
    check(req == 0, "R5 debt cleared by cap grants", req, 0);
    // R7: grant during busy is ignored
    wait_tick(2);
    wait_tick(2);
    grant = 1;
    @(negedge clk);
    @(negedge clk);
    grant = 0;
    check(busy == 1, "R6 busy after accept", busy, 1);
    repeat (TRFC - 1) @(negedge clk);
    check(busy == 0, "R7 busy not extended", busy, 0);
    check(req == 1, "R7 debt kept", req, 1);
    grant = 1;
    @(negedge clk);
    grant = 0;
    check(busy == 1, "R6 busy on second accept", busy, 1);
    check(req == 0, "R6 debt decremented", req, 0);
    // R8: grant with no debt
    repeat (TRFC) @(negedge clk);
    grant = 1;
    @(negedge clk);
    grant = 0;
    check(busy == 0, "R8 grant without debt", busy, 0);
    // R9: grant on the same edge as a mark
    wait_tick(INT - 1);
    wait_tick(INT - 1);
    grant = 1;
    @(negedge clk);
    grant = 0;
    check(busy == 1, "R9 grant accepted at mark", busy, 1);
    check(req == 1, "R9 debt unchanged", req, 1);
    repeat (TRFC) @(negedge clk);
    grant = 1;
    @(negedge clk);
    grant = 0;
    check(req == 0, "R9 debt was exactly one", req, 0);
    // Random arbiter phase
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      grant = (i % 1000 < 500) ? (lfsr[3:0] == 0) : (lfsr[1:0] != 0);
      @(negedge clk);
    end
    grant = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule